// File: doc/BRIEF.md
# Program Fetch Router with Multiplexed External Bus Sequencer

This block sits between an instruction fetch stage and program memory. For every accepted fetch it decides, from the 16-bit address and an external-access strap pin, whether the instruction byte comes from the on-chip ROM or from an external ROM. It then returns the byte with a one-cycle valid strobe. On-chip reads finish in a single clock. External reads run a four-state cycle on a pin-saving bus. The low address byte and the returned data share one port. The high address byte sits on a second port.

In an external cycle, the first state drives the low address byte on the shared port and raises the address-latch strobe, so a board-level latch can hold that byte. In the second state the strobe falls and the shared port is released. The third and fourth states pull the active-low program-read enable down, which makes the external ROM drive the bus. The byte is captured on the clock edge that ends the fourth state. A ready/busy signal holds off new requests until the cycle is over.

The on-chip ROM is a synchronous read of a computed content pattern, so its contents are known without an initialisation file.

Top module: `ext_fetch_ctrl`

## Requirements
- R1: After reset, fetch_ready is 1, ale is 0, psen_n is 1, p0_oe is 0 and instr_valid is 0.
- R2: With ea_strap = 1 and an address below 1000h, the fetch is on-chip. In the clock after acceptance, instr_valid is 1 and instr_data equals addr[7:0] ^ {addr[11:8], addr[11:8]} ^ 5Ah. ale stays 0, psen_n stays 1 and fetch_ready stays 1, so back-to-back on-chip fetches are accepted in consecutive clocks.
- R3: With ea_strap = 1 and an address of 1000h or above, the fetch runs an external cycle.
- R4: With ea_strap = 0, every address from 0000h to FFFFh, including 0000h, runs an external cycle.
- R5: In the first clock after an external fetch is accepted (address state), ale = 1, p0_oe = 1, p0_out = the low address byte and psen_n = 1.
- R6: In the second clock (latch state), ale = 0, p0_oe = 0 and psen_n = 1.
- R7: In the third and fourth clocks (read and capture states), psen_n = 0, ale = 0 and p0_oe = 0.
- R8: p2_out carries the high address byte in all four states of an external cycle. When no external cycle is running, p2_out is FFh.
- R9: The external byte is the value of p0_in at the clock edge that ends the capture state. In the clock after that edge, instr_valid = 1, instr_data holds that byte, psen_n = 1 and fetch_ready = 1.
- R10: fetch_ready is 0 during the four states of an external cycle. A request made while fetch_ready is 0 is ignored: it produces no instr_valid, and the cycle in progress completes with its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request, accepted when fetch_ready is 1 |
| fetch_addr | input | 16 | Program address of the fetch |
| ea_strap | input | 1 | External-access strap: 1 keeps the low 4 KB on-chip |
| fetch_ready | output | 1 | 1 when a request can be accepted |
| instr_valid | output | 1 | One-cycle strobe for a returned byte |
| instr_data | output | 8 | Returned instruction byte |
| ale | output | 1 | Address-latch strobe for the low address byte |
| psen_n | output | 1 | Active-low external program read enable |
| p0_out | output | 8 | Shared port output value (low address byte) |
| p0_oe | output | 1 | Shared port output enable |
| p0_in | input | 8 | Shared port input (external data) |
| p2_out | output | 8 | High address byte port |

## Verification
An on-chip result is due one clock after the accepting edge. The external phases fall in the first to fourth clocks after acceptance, and the external byte is due in the fifth. The bench drives inputs and samples outputs on falling edges, and checks each phase at the falling edge of its own clock. To pin down the capture edge, p0_in carries a wrong value during the read clock and after the capture edge, and the correct byte only during the capture clock. A request raised during a busy cycle is held for two clocks, and the bench confirms that no strobe appears before the pending byte.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int ADDR_W_DEF   = 16;
    localparam int DATA_W_DEF   = 8;
    localparam int INT_AW_DEF   = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LATCH,
        ST_READ,
        ST_CAPTURE
    } bus_state_e;

    // content of the on-chip ROM, computed from its address
    function automatic logic [7:0] rom_pattern(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

endpackage

// File: rtl/fetch_route.sv
module fetch_route #(
    parameter int ADDR_W = 16,
    parameter int INT_AW = 12,
    localparam int HI_W  = ADDR_W - INT_AW
) (
    input  logic [HI_W-1:0] addr_hi,
    input  logic            ea_strap,
    output logic            is_internal
);
    always_comb begin
        is_internal = ea_strap && (addr_hi == '0);
    end
endmodule

// File: rtl/int_rom.sv
module int_rom #(
    parameter int INT_AW = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [INT_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    import fetch_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= DATA_W'(rom_pattern(12'(rd_addr)));
            end
        end
    end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_in,
    output logic              busy,
    output logic              ale,
    output logic              psen_n,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [HI_W-1:0]   hi_out,
    output logic              done,
    output logic [DATA_W-1:0] data
);
    import fetch_pkg::*;

    bus_state_e        state;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            done   <= 1'b0;
            data   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= addr;
                        state  <= ST_ADDR;
                    end
                end
                ST_ADDR:  state <= ST_LATCH;
                ST_LATCH: state <= ST_READ;
                ST_READ:  state <= ST_CAPTURE;
                ST_CAPTURE: begin
                    data  <= bus_in;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (state != ST_IDLE);
        ale     = (state == ST_ADDR);
        bus_oe  = (state == ST_ADDR);
        bus_out = (state == ST_ADDR) ? addr_q[DATA_W-1:0] : '0;
        psen_n  = !((state == ST_READ) || (state == ST_CAPTURE));
        hi_out  = busy ? addr_q[ADDR_W-1:DATA_W] : '1;
    end
endmodule

// File: rtl/ext_fetch_ctrl.sv
module ext_fetch_ctrl #(
    parameter int ADDR_W = fetch_pkg::ADDR_W_DEF,
    parameter int DATA_W = fetch_pkg::DATA_W_DEF,
    parameter int INT_AW = fetch_pkg::INT_AW_DEF,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              ea_strap,
    output logic              fetch_ready,
    output logic              instr_valid,
    output logic [DATA_W-1:0] instr_data,
    output logic              ale,
    output logic              psen_n,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    input  logic [DATA_W-1:0] p0_in,
    output logic [HI_W-1:0]   p2_out
);
    logic              is_internal;
    logic              accept;
    logic              int_go;
    logic              ext_go;
    logic              ext_busy;
    logic              ext_done;
    logic [DATA_W-1:0] ext_data;
    logic              int_valid;
    logic [DATA_W-1:0] int_data;

    fetch_route #(.ADDR_W(ADDR_W), .INT_AW(INT_AW)) u_route (
        .addr_hi     (fetch_addr[ADDR_W-1:INT_AW]),
        .ea_strap    (ea_strap),
        .is_internal (is_internal)
    );

    always_comb begin
        fetch_ready = !ext_busy;
        accept      = fetch_req && fetch_ready;
        int_go      = accept && is_internal;
        ext_go      = accept && !is_internal;
    end

    int_rom #(.INT_AW(INT_AW), .DATA_W(DATA_W)) u_rom (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (int_go),
        .rd_addr  (fetch_addr[INT_AW-1:0]),
        .rd_data  (int_data),
        .rd_valid (int_valid)
    );

    ext_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (ext_go),
        .addr    (fetch_addr),
        .bus_in  (p0_in),
        .busy    (ext_busy),
        .ale     (ale),
        .psen_n  (psen_n),
        .bus_out (p0_out),
        .bus_oe  (p0_oe),
        .hi_out  (p2_out),
        .done    (ext_done),
        .data    (ext_data)
    );

    always_comb begin
        instr_valid = int_valid || ext_done;
        instr_data  = ext_done ? ext_data : int_data;
    end
endmodule

// File: rtl/ext_fetch_ctrl_chk.sv
module ext_fetch_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_ready,
    input logic              instr_valid,
    input logic              ale,
    input logic              psen_n,
    input logic              p0_oe,
    input logic [HI_W-1:0]   p2_out
);
    // R5
    ale_drives_port_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> p0_oe && psen_n && !fetch_ready);

    // R6
    ale_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale && !p0_oe && psen_n);

    // R7
    read_port_free_chk: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> !ale && !p0_oe && !fetch_ready);

    // R9
    byte_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(psen_n) |-> instr_valid && fetch_ready);

    // R2
    valid_quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid |-> !ale && psen_n);

    // R8
    high_byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_ready && !ale |-> $stable(p2_out));
endmodule

bind ext_fetch_ctrl ext_fetch_ctrl_chk #(.DATA_W(DATA_W), .HI_W(HI_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_ready (fetch_ready),
    .instr_valid (instr_valid),
    .ale         (ale),
    .psen_n      (psen_n),
    .p0_oe       (p0_oe),
    .p2_out      (p2_out)
);

// File: tb/ext_fetch_ctrl_bench.sv
`timescale 1ns/1ps
module ext_fetch_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_req;
    logic [15:0] fetch_addr;
    logic        ea_strap;
    logic        fetch_ready;
    logic        instr_valid;
    logic [7:0]  instr_data;
    logic        ale;
    logic        psen_n;
    logic [7:0]  p0_out;
    logic        p0_oe;
    logic [7:0]  p0_in;
    logic [7:0]  p2_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    ext_fetch_ctrl u_ext_fetch_ctrl (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .ea_strap(ea_strap), .fetch_ready(fetch_ready), .instr_valid(instr_valid),
        .instr_data(instr_data), .ale(ale), .psen_n(psen_n), .p0_out(p0_out),
        .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out)
    );

    function automatic logic [7:0] exp_rom(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // checks the five clocks of an external fetch; request goes up at a negedge
    task automatic ext_fetch(input string req, input logic [15:0] a,
                             input logic ea, input logic [7:0] byte_v);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a; ea_strap = ea; p0_in = ~byte_v;
        @(negedge clk);
        fetch_req = 1'b0;
        chk(req, "R5 ale",    16'(ale), 16'd1);
        chk(req, "R5 p0_oe",  16'(p0_oe), 16'd1);
        chk(req, "R5 p0_out", 16'(p0_out), 16'(a[7:0]));
        chk(req, "R5 psen_n", 16'(psen_n), 16'd1);
        chk(req, "R8 p2_out", 16'(p2_out), 16'(a[15:8]));
        chk(req, "R10 ready", 16'(fetch_ready), 16'd0);
        @(negedge clk);
        chk(req, "R6 ale",    16'(ale), 16'd0);
        chk(req, "R6 p0_oe",  16'(p0_oe), 16'd0);
        chk(req, "R6 psen_n", 16'(psen_n), 16'd1);
        chk(req, "R8 p2_out", 16'(p2_out), 16'(a[15:8]));
        @(negedge clk);
        chk(req, "R7 psen_n read", 16'(psen_n), 16'd0);
        chk(req, "R7 p0_oe read",  16'(p0_oe), 16'd0);
        chk(req, "R8 p2_out",      16'(p2_out), 16'(a[15:8]));
        p0_in = byte_v;
        @(negedge clk);
        chk(req, "R7 psen_n capture", 16'(psen_n), 16'd0);
        chk(req, "R8 p2_out",         16'(p2_out), 16'(a[15:8]));
        chk(req, "R10 no strobe",     16'(instr_valid), 16'd0);
        @(negedge clk);
        p0_in = 8'h00;
        chk(req, "R9 valid",  16'(instr_valid), 16'd1);
        chk(req, "R9 data",   16'(instr_data), 16'(byte_v));
        chk(req, "R9 psen_n", 16'(psen_n), 16'd1);
        chk(req, "R9 ready",  16'(fetch_ready), 16'd1);
        chk(req, "R8 idle p2", 16'(p2_out), 16'hFF);
    endtask

    task automatic t_reset();
        rst = 1'b1; fetch_req = 1'b0; fetch_addr = '0; ea_strap = 1'b1; p0_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready",  16'(fetch_ready), 16'd1);
        chk("R1", "ale",    16'(ale), 16'd0);
        chk("R1", "psen_n", 16'(psen_n), 16'd1);
        chk("R1", "p0_oe",  16'(p0_oe), 16'd0);
        chk("R1", "valid",  16'(instr_valid), 16'd0);
    endtask

    // R2: single and back-to-back on-chip fetches
    task automatic t_internal();
        logic [15:0] addrs [4] = '{16'h0000, 16'h0123, 16'h0ABC, 16'h0FFF};
        foreach (addrs[i]) begin
            @(negedge clk);
            fetch_req = 1'b1; fetch_addr = addrs[i]; ea_strap = 1'b1;
            if (i > 0) begin
                chk("R2", "b2b valid", 16'(instr_valid), 16'd1);
                chk("R2", "b2b data",  16'(instr_data), 16'(exp_rom(addrs[i-1])));
                chk("R2", "ready",     16'(fetch_ready), 16'd1);
                chk("R2", "ale",       16'(ale), 16'd0);
                chk("R2", "psen_n",    16'(psen_n), 16'd1);
            end
        end
        @(negedge clk);
        fetch_req = 1'b0;
        chk("R2", "last valid", 16'(instr_valid), 16'd1);
        chk("R2", "last data",  16'(instr_data), 16'(exp_rom(16'h0FFF)));
        @(negedge clk);
        chk("R2", "strobe ends", 16'(instr_valid), 16'd0);
    endtask

    task automatic t_external_strap_high();
        ext_fetch("R3", 16'h1000, 1'b1, 8'hC3);
        ext_fetch("R3", 16'hFFFF, 1'b1, 8'h3C);
        ext_fetch("R3", 16'h8A55, 1'b1, 8'h96);
    endtask

    task automatic t_external_strap_low();
        ext_fetch("R4", 16'h0000, 1'b0, 8'hA5);
        ext_fetch("R4", 16'h0FFF, 1'b0, 8'h5A);
    endtask

    // R10: a request during the busy window is dropped
    task automatic t_busy_ignore();
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 16'h2345; ea_strap = 1'b1; p0_in = 8'h00;
        @(negedge clk);
        fetch_addr = 16'h0012;
        @(negedge clk);
        chk("R10", "busy ready", 16'(fetch_ready), 16'd0);
        chk("R10", "no strobe latch", 16'(instr_valid), 16'd0);
        fetch_req = 1'b0;
        @(negedge clk);
        chk("R10", "no strobe read", 16'(instr_valid), 16'd0);
        chk("R10", "p2 kept", 16'(p2_out), 16'h23);
        p0_in = 8'h77;
        @(negedge clk);
        chk("R10", "no strobe capture", 16'(instr_valid), 16'd0);
        @(negedge clk);
        p0_in = 8'h00;
        chk("R10", "own byte", 16'(instr_data), 16'h77);
        chk("R10", "own valid", 16'(instr_valid), 16'd1);
        @(negedge clk);
        chk("R10", "single strobe", 16'(instr_valid), 16'd0);
        chk("R10", "no late cycle", 16'(ale), 16'd0);
    endtask

    initial begin
        t_reset();
        t_internal();
        t_external_strap_high();
        t_external_strap_low();
        t_busy_ignore();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule